// File: doc/BRIEF.md
# I2C Controller Clock-Hold Decision Logic

This block sits beside the SCL generator of an I2C controller and decides when the controller must keep SCL low because software has fallen behind the byte engine. The byte engine reports each SCL falling edge together with its position within the current byte. The block combines that edge with the buffer flags, the remaining-byte count, NACK status and a pending repeated-START request. It then raises a hold request that the SCL generator obeys.

Three independent hold reasons are tracked. The first is an unread received byte while the next byte arrives, which holds at falling edge 7. The second is an empty transmit buffer with bytes still to send, which holds at falling edge 8. The third is a requested repeated START after a NACK or when the count is exhausted, which holds at falling edge 9. Each reason keeps its own registered hold bit and is cleared by its own software event. SCL is freed only after every active reason has been released. When the repeated-START hold is released, a one-cycle pulse tells the byte engine to issue the repeated START. A status flag mirrors the hold so that software can see that the controller is waiting on it.

Top module: `scl_hold_ctrl`

## Requirements
- R1: After a synchronous reset, `scl_hold`, `data_req` and `restart_go` are all 0.
- R2: A cycle with `scl_fall`=1, `edge_idx`=7, `host_active`=1 and `rx_full`=1 makes `scl_hold` 1 from the next cycle. It stays 1 until a cycle with `sw_rx_read`=1, and it is 0 in the cycle after that read.
- R3: A cycle with `scl_fall`=1, `edge_idx`=8, `host_active`=1, `tx_empty`=1 and `byte_left`≠0 makes `scl_hold` 1 from the next cycle. A cycle with `sw_tx_write`=1 releases it, and `scl_hold` is 0 in the cycle after that write.
- R4: With `byte_left`=0, an empty transmit buffer at edge 8 causes no hold.
- R5: A cycle with `scl_fall`=1, `edge_idx`=9, `host_active`=1, `restart_req`=1 and either `nack_seen`=1 or `byte_left`=0 makes `scl_hold` 1 from the next cycle.
- R6: While `addr_buf_mode`=0, the edge-9 hold is released only by `sw_start_set`. A `sw_tx_write` leaves `scl_hold` at 1.
- R7: While `addr_buf_mode`=1, the edge-9 hold is released only by `sw_tx_write`. A `sw_start_set` leaves `scl_hold` at 1.
- R8: Releasing the edge-9 hold makes `restart_go` 1 for exactly the one cycle after the release event. No other release makes it 1.
- R9: `data_req` equals `scl_hold` in every cycle.
- R10: While `host_active`=0, no hold is taken. Dropping `host_active` clears any hold in the next cycle.
- R11: A condition shown with `scl_fall`=0, or on any other edge index than its own, causes no hold.
- R12: When two hold reasons are active together, releasing one leaves `scl_hold` at 1. Releasing the other then frees SCL.
- R13: If a reason's release event arrives in the same cycle as its set condition, no hold is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_active | input | 1 | Controller currently owns the bus |
| scl_fall | input | 1 | One-cycle pulse marking an SCL falling edge |
| edge_idx | input | EDGE_W | Index (1..9) of that falling edge within the byte |
| rx_full | input | 1 | Receive buffer holds an unread byte |
| tx_empty | input | 1 | Transmit buffer holds no data |
| byte_left | input | CNT_W | Remaining-byte counter |
| nack_seen | input | 1 | A NACK was detected on the bus |
| restart_req | input | 1 | Software requested a repeated START |
| addr_buf_mode | input | 1 | Selects the restart release event (0: START bit, 1: transmit write) |
| sw_rx_read | input | 1 | Software read the receive buffer |
| sw_tx_write | input | 1 | Software wrote the transmit buffer |
| sw_start_set | input | 1 | Software set the START bit |
| scl_hold | output | 1 | Request to hold SCL low |
| data_req | output | 1 | Status flag: the controller waits on software |
| restart_go | output | 1 | One-cycle pulse to issue the repeated START |

## Verification
The bench builds the block with `CNT_W`=4 and the default edge positions 7, 8 and 9. A 4-bit counter keeps the zero and nonzero count cases cheap to reach. The bench sweeps every edge index from 1 to 9 against all 64 combinations of host-active, receive-full, transmit-empty, zero count, NACK and restart request, so every set condition and every near miss is covered. Directed sequences then cover both restart release modes, the restart pulse, overlapping holds, a release that cancels a set in the same cycle, and a hold cleared by loss of bus ownership.

// File: rtl/scl_hold_pkg.sv
package scl_hold_pkg;
  localparam int NUM_COND = 3;
  localparam int C_RX = 0;
  localparam int C_TX = 1;
  localparam int C_RS = 2;
endpackage

// File: rtl/hold_cond_eval.sv
module hold_cond_eval
  import scl_hold_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int EDGE_W  = 4,
  parameter int RX_EDGE = 7,
  parameter int TX_EDGE = 8,
  parameter int RS_EDGE = 9
) (
  input  logic              host_active,
  input  logic              scl_fall,
  input  logic [EDGE_W-1:0] edge_idx,
  input  logic              rx_full,
  input  logic              tx_empty,
  input  logic [CNT_W-1:0]  byte_left,
  input  logic              nack_seen,
  input  logic              restart_req,
  input  logic              addr_buf_mode,
  input  logic              sw_rx_read,
  input  logic              sw_tx_write,
  input  logic              sw_start_set,
  output logic [NUM_COND-1:0] set_vec,
  output logic [NUM_COND-1:0] rel_vec
);
  localparam logic [EDGE_W-1:0] RX_E = EDGE_W'(RX_EDGE);
  localparam logic [EDGE_W-1:0] TX_E = EDGE_W'(TX_EDGE);
  localparam logic [EDGE_W-1:0] RS_E = EDGE_W'(RS_EDGE);

  logic live;
  logic cnt_zero;

  always_comb begin
    live     = host_active & scl_fall;
    cnt_zero = (byte_left == '0);

    set_vec          = '0;
    set_vec[C_RX]    = live & (edge_idx == RX_E) & rx_full;
    set_vec[C_TX]    = live & (edge_idx == TX_E) & tx_empty & ~cnt_zero;
    set_vec[C_RS]    = live & (edge_idx == RS_E) & restart_req & (nack_seen | cnt_zero);

    rel_vec          = '0;
    rel_vec[C_RX]    = sw_rx_read;
    rel_vec[C_TX]    = sw_tx_write;
    rel_vec[C_RS]    = addr_buf_mode ? sw_tx_write : sw_start_set;
  end
endmodule

// File: rtl/hold_latch.sv
module hold_latch (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic set,
  input  logic rel,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst || clr) q <= 1'b0;
    else            q <= (q | set) & ~rel;
  end

  assert_latch_capture_R2: assert property (@(posedge clk) disable iff (rst)
    (set && !rel && !clr) |=> q);
  assert_latch_release_R6: assert property (@(posedge clk) disable iff (rst)
    (q && rel) |=> !q);
  assert_latch_keep_R12: assert property (@(posedge clk) disable iff (rst)
    (q && !rel && !clr) |=> q);
  assert_latch_cancel_R13: assert property (@(posedge clk) disable iff (rst)
    (!q && rel) |=> !q);
endmodule

// File: rtl/scl_hold_ctrl.sv
module scl_hold_ctrl
  import scl_hold_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int EDGE_W  = 4,
  parameter int RX_EDGE = 7,
  parameter int TX_EDGE = 8,
  parameter int RS_EDGE = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_active,
  input  logic              scl_fall,
  input  logic [EDGE_W-1:0] edge_idx,
  input  logic              rx_full,
  input  logic              tx_empty,
  input  logic [CNT_W-1:0]  byte_left,
  input  logic              nack_seen,
  input  logic              restart_req,
  input  logic              addr_buf_mode,
  input  logic              sw_rx_read,
  input  logic              sw_tx_write,
  input  logic              sw_start_set,
  output logic              scl_hold,
  output logic              data_req,
  output logic              restart_go
);
  logic [NUM_COND-1:0] set_vec;
  logic [NUM_COND-1:0] rel_vec;
  logic [NUM_COND-1:0] hold_q;
  logic                go_q;

  hold_cond_eval #(
    .CNT_W(CNT_W), .EDGE_W(EDGE_W),
    .RX_EDGE(RX_EDGE), .TX_EDGE(TX_EDGE), .RS_EDGE(RS_EDGE)
  ) u_eval (
    .host_active(host_active), .scl_fall(scl_fall), .edge_idx(edge_idx),
    .rx_full(rx_full), .tx_empty(tx_empty), .byte_left(byte_left),
    .nack_seen(nack_seen), .restart_req(restart_req),
    .addr_buf_mode(addr_buf_mode), .sw_rx_read(sw_rx_read),
    .sw_tx_write(sw_tx_write), .sw_start_set(sw_start_set),
    .set_vec(set_vec), .rel_vec(rel_vec)
  );

  for (genvar i = 0; i < NUM_COND; i++) begin : g_cond
    hold_latch u_latch (
      .clk(clk), .rst(rst), .clr(~host_active),
      .set(set_vec[i]), .rel(rel_vec[i]), .q(hold_q[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) go_q <= 1'b0;
    else     go_q <= hold_q[C_RS] & rel_vec[C_RS] & host_active;
  end

  assign scl_hold   = |hold_q;
  assign data_req   = |hold_q;
  assign restart_go = go_q;

  assert_idle_when_inactive_R10: assert property (@(posedge clk) disable iff (rst)
    !host_active |=> !scl_hold);
  assert_go_follows_hold_R8: assert property (@(posedge clk) disable iff (rst)
    restart_go |-> $past(scl_hold));
  assert_go_single_R8: assert property (@(posedge clk) disable iff (rst)
    restart_go |=> !restart_go);
endmodule

// File: tb/scl_hold_ctrl_bench.sv
module scl_hold_ctrl_bench;
  localparam int CW = 4;
  logic clk = 1'b0;
  logic rst;
  logic host_active, scl_fall, rx_full, tx_empty, nack_seen, restart_req;
  logic addr_buf_mode, sw_rx_read, sw_tx_write, sw_start_set;
  logic [3:0] edge_idx;
  logic [CW-1:0] byte_left;
  logic scl_hold, data_req, restart_go;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  scl_hold_ctrl #(.CNT_W(CW)) u_scl_hold_ctrl (
    .clk(clk), .rst(rst), .host_active(host_active), .scl_fall(scl_fall),
    .edge_idx(edge_idx), .rx_full(rx_full), .tx_empty(tx_empty),
    .byte_left(byte_left), .nack_seen(nack_seen), .restart_req(restart_req),
    .addr_buf_mode(addr_buf_mode), .sw_rx_read(sw_rx_read),
    .sw_tx_write(sw_tx_write), .sw_start_set(sw_start_set),
    .scl_hold(scl_hold), .data_req(data_req), .restart_go(restart_go)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle_inputs();
    scl_fall = 0; edge_idx = 0; rx_full = 0; tx_empty = 0; byte_left = 0;
    nack_seen = 0; restart_req = 0; sw_rx_read = 0; sw_tx_write = 0;
    sw_start_set = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1; idle_inputs();
    @(negedge clk); rst = 0;
  endtask

  // one falling-edge event, outputs checked one cycle later
  task automatic fall_at(input int e, input logic rxf, input logic txe,
                         input logic [CW-1:0] cnt, input logic nk, input logic rr);
    @(negedge clk);
    scl_fall = 1; edge_idx = 4'(e); rx_full = rxf; tx_empty = txe;
    byte_left = cnt; nack_seen = nk; restart_req = rr;
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic pulse(input logic rd, input logic wr, input logic st);
    @(negedge clk);
    sw_rx_read = rd; sw_tx_write = wr; sw_start_set = st;
    @(negedge clk);
    sw_rx_read = 0; sw_tx_write = 0; sw_start_set = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst = 1; host_active = 0; addr_buf_mode = 0; idle_inputs();
    repeat (2) @(negedge clk);
    chk("R1 hold", scl_hold, 1'b0);
    chk("R1 req", data_req, 1'b0);
    chk("R1 go", restart_go, 1'b0);
    rst = 0;

    // sweep: edges 1..9 x all flag combinations (R2 R3 R4 R5 R9 R10 R11)
    for (int e = 1; e <= 9; e++) begin
      for (int v = 0; v < 64; v++) begin
        logic act, rxf, txe, cz, nk, rr, exp;
        logic [CW-1:0] cnt;
        {act, rxf, txe, cz, nk, rr} = 6'(v);
        cnt = cz ? '0 : CW'(3);
        do_reset();
        host_active = act;
        exp = act & ((e == 7 & rxf) | (e == 8 & txe & ~cz) |
                     (e == 9 & rr & (nk | cz)));
        fall_at(e, rxf, txe, cnt, nk, rr);
        chk("R2/R3/R4/R5/R10/R11 sweep hold", scl_hold, exp);
        chk("R9 req mirrors hold", data_req, scl_hold);
      end
    end

    // R11: conditions present with no falling-edge pulse
    do_reset(); host_active = 1;
    @(negedge clk); edge_idx = 7; rx_full = 1; tx_empty = 1; byte_left = 2;
    @(negedge clk); idle_inputs();
    chk("R11 no scl_fall", scl_hold, 1'b0);

    // R2 hold persists then release
    do_reset(); host_active = 1;
    fall_at(7, 1, 0, 2, 0, 0);
    repeat (3) @(negedge clk);
    chk("R2 held", scl_hold, 1'b1);
    pulse(0, 1, 1);
    chk("R2 other events ignored", scl_hold, 1'b1);
    pulse(1, 0, 0);
    chk("R2 released", scl_hold, 1'b0);
    chk("R8 no go on rx release", restart_go, 1'b0);

    // R3 release
    do_reset(); host_active = 1;
    fall_at(8, 0, 1, 5, 0, 0);
    chk("R3 held", scl_hold, 1'b1);
    pulse(1, 0, 1);
    chk("R3 other events ignored", scl_hold, 1'b1);
    pulse(0, 1, 0);
    chk("R3 released", scl_hold, 1'b0);
    chk("R8 no go on tx release", restart_go, 1'b0);

    // R6 mode 0 restart release
    do_reset(); host_active = 1; addr_buf_mode = 0;
    fall_at(9, 0, 0, 0, 0, 1);
    chk("R5 held", scl_hold, 1'b1);
    pulse(0, 1, 0);
    chk("R6 tx write ignored", scl_hold, 1'b1);
    chk("R8 no go", restart_go, 1'b0);
    @(negedge clk); sw_start_set = 1;
    @(negedge clk); sw_start_set = 0;
    chk("R6 start releases", scl_hold, 1'b0);
    chk("R8 go pulse", restart_go, 1'b1);
    @(negedge clk);
    chk("R8 go one cycle", restart_go, 1'b0);

    // R7 mode 1 restart release
    do_reset(); host_active = 1; addr_buf_mode = 1;
    fall_at(9, 0, 0, 4, 1, 1);
    chk("R5 nack hold", scl_hold, 1'b1);
    pulse(0, 0, 1);
    chk("R7 start ignored", scl_hold, 1'b1);
    @(negedge clk); sw_tx_write = 1;
    @(negedge clk); sw_tx_write = 0;
    chk("R7 tx write releases", scl_hold, 1'b0);
    chk("R8 go pulse mode1", restart_go, 1'b1);
    @(negedge clk);
    chk("R8 go one cycle mode1", restart_go, 1'b0);
    addr_buf_mode = 0;

    // R12 overlapping holds
    do_reset(); host_active = 1;
    fall_at(7, 1, 0, 2, 0, 0);
    fall_at(8, 0, 1, 2, 0, 0);
    chk("R12 both held", scl_hold, 1'b1);
    pulse(1, 0, 0);
    chk("R12 one released still held", scl_hold, 1'b1);
    chk("R9 req while held", data_req, 1'b1);
    pulse(0, 1, 0);
    chk("R12 all released", scl_hold, 1'b0);
    chk("R9 req after release", data_req, 1'b0);

    // R13 release coinciding with set
    do_reset(); host_active = 1;
    @(negedge clk); scl_fall = 1; edge_idx = 7; rx_full = 1; sw_rx_read = 1;
    @(negedge clk); idle_inputs();
    chk("R13 cancel", scl_hold, 1'b0);

    // R10 dropping host_active clears hold
    do_reset(); host_active = 1;
    fall_at(8, 0, 1, 1, 0, 0);
    chk("R10 pre hold", scl_hold, 1'b1);
    @(negedge clk); host_active = 0;
    @(negedge clk);
    chk("R10 cleared", scl_hold, 1'b0);
    host_active = 1;
    @(negedge clk);
    chk("R10 stays clear", scl_hold, 1'b0);

    // R1 reset clears a hold
    fall_at(7, 1, 0, 1, 0, 0);
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    chk("R1 reset clears", scl_hold, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule